// File: doc/BRIEF.md
# Trace Message Packetizer

This block turns one debug trace message at a time into a stream of 12-bit output beats. Each beat carries a 2-bit marker that tells a receiver where messages begin and end. A producer offers a message on a valid/ready request port. The message carries a kind, a 4-bit source identifier and the payload fields that kind needs. The block then emits the message beat by beat and takes no new request until the message has left.

The four message kinds are debug status, ownership trace, direct-branch program trace and indirect-branch program trace. The first beat always holds only the header: a 6-bit type code and the 4-bit source identifier. The payload packets follow in a fixed order, least significant bits first. Each packet fills 12-bit beats and is zero-padded in its last beat. A variable packet (instruction count or branch address) is cut to its significant bits: leading zeros are dropped, and at least one bit is kept. Its length therefore sets how many beats it takes, and it always ends on a beat boundary.

Top module: `trace_packetizer`

## Requirements
- R1: While in reset, and whenever no message is being sent, msgMark is 2'b11, msgData is zero and reqReady is high.
- R2: In the cycle after a handshake (reqValid and reqReady high at a clock edge), msgMark is 2'b00 (start) and msgData is {2'b00, reqSrc, typeCode}, with the type code in bits 5:0 and the source in bits 9:6.
- R3: reqKind selects the type code: 0 is debug status (code 0), 1 is ownership trace (code 2), 2 is direct branch (code 3) and 3 is indirect branch (code 4).
- R4: A debug status message has one payload beat holding reqStatus in bits 7:0 with zero above it, marked 2'b11 (end of message).
- R5: An ownership message sends the 32-bit reqProcId in three beats, bits 11:0 first, then 23:12, then 31:24. The beats are marked 2'b10, 2'b10 and 2'b11.
- R6: A direct-branch message has one payload beat holding reqICnt, marked 2'b11 (end of message takes priority over end of variable packet).
- R7: An indirect-branch message sends a reqICnt beat marked 2'b01 (end of variable packet), then the address beats. Every address beat is marked 2'b10 except the last, which is marked 2'b11.
- R8: The address packet takes ceil(n/12) beats, where n is the position of the highest set bit of reqAddr plus one. A zero address counts as n = 1 and gives one all-zero beat.
- R9: reqReady is low from the handshake until the end-of-message beat has left. Request inputs that change while it is low do not alter the message being sent.
- R10: After an end-of-message beat, the output shows at least one idle beat (2'b11, zero data) with reqReady high before the next start beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Block can accept a request |
| reqKind | input | 2 | Message kind (see R3) |
| reqSrc | input | 4 | Source identifier |
| reqStatus | input | 8 | Debug status byte |
| reqProcId | input | 32 | Process ID for ownership trace |
| reqICnt | input | 8 | Instruction count since last taken branch |
| reqAddr | input | 32 | Unique part of branch target address |
| msgData | output | 12 | Output beat data |
| msgMark | output | 2 | Beat marker: 00 start, 01 end of variable packet, 10 data, 11 end of message or idle |

## Verification
The four kinds are each sent with distinct sources, so a wrong type code or a misplaced header field shows up. Addresses of zero, 0xFFF, 0x1000, 0xFFFFFF, 0x1000000 and all-ones sit on either side of each 12-bit beat boundary, which separates off-by-one trimming from correct beat counts. Instruction counts of 0 and 0xFF test the one-bit minimum and the full width. Requests held valid back to back, with fields changed while the block is busy, show whether content is captured only at the handshake and whether the idle beat appears between messages.

// File: rtl/trcpk_pkg.sv
package trcpk_pkg;

  localparam int CODE_W = 6;

  typedef enum logic [1:0] {
    KIND_DBG = 2'd0,
    KIND_OWN = 2'd1,
    KIND_DIR = 2'd2,
    KIND_IND = 2'd3
  } msgKind_e;

  localparam logic [1:0] MARK_START = 2'b00;
  localparam logic [1:0] MARK_VEND  = 2'b01;
  localparam logic [1:0] MARK_DATA  = 2'b10;
  localparam logic [1:0] MARK_EOM   = 2'b11;

  localparam logic [CODE_W-1:0] CODE_DBG = 6'd0;
  localparam logic [CODE_W-1:0] CODE_OWN = 6'd2;
  localparam logic [CODE_W-1:0] CODE_DIR = 6'd3;
  localparam logic [CODE_W-1:0] CODE_IND = 6'd4;

  // which source the datapath puts on the output register next
  typedef enum logic [1:0] {
    BEAT_IDLE,
    BEAT_HEAD,
    BEAT_CUR,
    BEAT_SPARE
  } beatSel_e;

  typedef struct packed {
    beatSel_e   sel;
    logic [1:0] mark;
  } dpCtrl_t;

endpackage

// File: rtl/trcpk_sigwidth.sv
module trcpk_sigwidth #(
  parameter int W  = 32,
  parameter int LW = $clog2(W + 1)
) (
  input  logic [W-1:0]  value,
  output logic [LW-1:0] width
);

  // position of highest set bit plus one; a zero value keeps one bit
  always_comb begin
    width = LW'(1);
    for (int i = 1; i < W; i++) begin
      if (value[i]) width = LW'(i + 1);
    end
  end

endmodule

// File: rtl/trcpk_datapath.sv
module trcpk_datapath
  import trcpk_pkg::*;
#(
  parameter int BEAT_W = 12,
  parameter int SRC_W  = 4,
  parameter int STAT_W = 8,
  parameter int PID_W  = 32,
  parameter int ICNT_W = 8,
  parameter int ADDR_W = 32,
  parameter int PKT_W  = 32,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  msgKind_e          reqKind,
  input  logic [SRC_W-1:0]  reqSrc,
  input  logic [STAT_W-1:0] reqStatus,
  input  logic [PID_W-1:0]  reqProcId,
  input  logic [ICNT_W-1:0] reqICnt,
  input  logic [ADDR_W-1:0] reqAddr,
  input  dpCtrl_t           ctrl,
  output logic [CNT_W-1:0]  p0Beats,
  output logic [CNT_W-1:0]  p1Beats,
  output logic [BEAT_W-1:0] msgData,
  output logic [1:0]        msgMark
);

  localparam int LEN_W  = $clog2(PKT_W + 1);
  localparam int ICLW   = $clog2(ICNT_W + 1);
  localparam int ADLW   = $clog2(ADDR_W + 1);

  logic [ICLW-1:0]   icntLen;
  logic [ADLW-1:0]   addrLen;
  logic [LEN_W-1:0]  p0Len;
  logic [LEN_W-1:0]  p1Len;
  logic [PKT_W-1:0]  p0Val;
  logic [CODE_W-1:0] typeCode;
  logic [BEAT_W-1:0] headBeat;

  logic [PKT_W-1:0]  curReg;
  logic [PKT_W-1:0]  spareReg;
  logic [BEAT_W-1:0] dataReg;
  logic [1:0]        markReg;

  trcpk_sigwidth #(.W(ICNT_W), .LW(ICLW)) uIcntWidth (
    .value (reqICnt),
    .width (icntLen)
  );

  trcpk_sigwidth #(.W(ADDR_W), .LW(ADLW)) uAddrWidth (
    .value (reqAddr),
    .width (addrLen)
  );

  // first payload packet and its length, picked by kind
  always_comb begin
    unique case (reqKind)
      KIND_DBG: begin
        typeCode = CODE_DBG;
        p0Len    = LEN_W'(STAT_W);
        p0Val    = PKT_W'(reqStatus);
      end
      KIND_OWN: begin
        typeCode = CODE_OWN;
        p0Len    = LEN_W'(PID_W);
        p0Val    = PKT_W'(reqProcId);
      end
      KIND_DIR: begin
        typeCode = CODE_DIR;
        p0Len    = LEN_W'(icntLen);
        p0Val    = PKT_W'(reqICnt);
      end
      default: begin
        typeCode = CODE_IND;
        p0Len    = LEN_W'(icntLen);
        p0Val    = PKT_W'(reqICnt);
      end
    endcase
  end

  assign p1Len    = LEN_W'(addrLen);
  assign p0Beats  = CNT_W'((int'(p0Len) + BEAT_W - 1) / BEAT_W);
  assign p1Beats  = CNT_W'((int'(p1Len) + BEAT_W - 1) / BEAT_W);
  assign headBeat = BEAT_W'({reqSrc, typeCode});

  // trimmed packets have zeros above their length, so each beat is a
  // plain 12-bit slice with no masking
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curReg   <= '0;
      spareReg <= '0;
      dataReg  <= '0;
      markReg  <= MARK_EOM;
    end else begin
      markReg <= ctrl.mark;
      unique case (ctrl.sel)
        BEAT_HEAD: begin
          dataReg  <= headBeat;
          curReg   <= p0Val;
          spareReg <= PKT_W'(reqAddr);
        end
        BEAT_CUR: begin
          dataReg <= curReg[BEAT_W-1:0];
          curReg  <= curReg >> BEAT_W;
        end
        BEAT_SPARE: begin
          dataReg <= spareReg[BEAT_W-1:0];
          curReg  <= spareReg >> BEAT_W;
        end
        default: dataReg <= '0;
      endcase
    end
  end

  assign msgData = dataReg;
  assign msgMark = markReg;

endmodule

// File: rtl/trcpk_control.sv
module trcpk_control
  import trcpk_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  msgKind_e         reqKind,
  input  logic [CNT_W-1:0] p0Beats,
  input  logic [CNT_W-1:0] p1Beats,
  output logic             reqReady,
  output dpCtrl_t          ctrl
);

  typedef enum logic [1:0] {ST_IDLE, ST_HEAD, ST_P0, ST_P1} state_e;

  state_e           state, stateNxt;
  logic [CNT_W-1:0] rem, remNxt;
  logic [CNT_W-1:0] p1Cnt;
  logic             hasP1;

  assign reqReady = (state == ST_IDLE);

  always_comb begin
    ctrl.sel  = BEAT_IDLE;
    ctrl.mark = MARK_EOM;
    stateNxt  = state;
    remNxt    = rem;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          ctrl.sel  = BEAT_HEAD;
          ctrl.mark = MARK_START;
          stateNxt  = ST_HEAD;
          remNxt    = p0Beats;
        end
      end
      ST_HEAD, ST_P0: begin
        if (rem != '0) begin
          ctrl.sel  = BEAT_CUR;
          ctrl.mark = (rem != CNT_W'(1)) ? MARK_DATA :
                      (hasP1 ? MARK_VEND : MARK_EOM);
          remNxt    = rem - CNT_W'(1);
          stateNxt  = ST_P0;
        end else if (hasP1) begin
          ctrl.sel  = BEAT_SPARE;
          ctrl.mark = (p1Cnt == CNT_W'(1)) ? MARK_EOM : MARK_DATA;
          remNxt    = p1Cnt - CNT_W'(1);
          stateNxt  = ST_P1;
        end else begin
          stateNxt = ST_IDLE;
        end
      end
      default: begin
        if (rem != '0) begin
          ctrl.sel  = BEAT_CUR;
          ctrl.mark = (rem == CNT_W'(1)) ? MARK_EOM : MARK_DATA;
          remNxt    = rem - CNT_W'(1);
        end else begin
          stateNxt = ST_IDLE;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      rem   <= '0;
      p1Cnt <= '0;
      hasP1 <= 1'b0;
    end else begin
      state <= stateNxt;
      rem   <= remNxt;
      if (reqReady && reqValid) begin
        p1Cnt <= p1Beats;
        hasP1 <= (reqKind == KIND_IND);
      end
    end
  end

endmodule

// File: rtl/trace_packetizer.sv
module trace_packetizer
  import trcpk_pkg::*;
#(
  parameter int BEAT_W = 12,
  parameter int SRC_W  = 4,
  parameter int STAT_W = 8,
  parameter int PID_W  = 32,
  parameter int ICNT_W = 8,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [1:0]        reqKind,
  input  logic [SRC_W-1:0]  reqSrc,
  input  logic [STAT_W-1:0] reqStatus,
  input  logic [PID_W-1:0]  reqProcId,
  input  logic [ICNT_W-1:0] reqICnt,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic [BEAT_W-1:0] msgData,
  output logic [1:0]        msgMark
);

  localparam int MAX_A     = (PID_W > ADDR_W) ? PID_W : ADDR_W;
  localparam int MAX_B     = (STAT_W > ICNT_W) ? STAT_W : ICNT_W;
  localparam int PKT_W0    = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int PKT_W     = (PKT_W0 > BEAT_W) ? PKT_W0 : BEAT_W;
  localparam int MAX_BEATS = (PKT_W + BEAT_W - 1) / BEAT_W;
  localparam int CNT_W     = $clog2(MAX_BEATS + 1);

  msgKind_e         kind;
  dpCtrl_t          ctrl;
  logic [CNT_W-1:0] p0Beats;
  logic [CNT_W-1:0] p1Beats;

  assign kind = msgKind_e'(reqKind);

  trcpk_control #(.CNT_W(CNT_W)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqKind  (kind),
    .p0Beats  (p0Beats),
    .p1Beats  (p1Beats),
    .reqReady (reqReady),
    .ctrl     (ctrl)
  );

  trcpk_datapath #(
    .BEAT_W (BEAT_W), .SRC_W (SRC_W), .STAT_W (STAT_W), .PID_W (PID_W),
    .ICNT_W (ICNT_W), .ADDR_W (ADDR_W), .PKT_W (PKT_W), .CNT_W (CNT_W)
  ) uData (
    .clk       (clk),
    .rstN      (rstN),
    .reqKind   (kind),
    .reqSrc    (reqSrc),
    .reqStatus (reqStatus),
    .reqProcId (reqProcId),
    .reqICnt   (reqICnt),
    .reqAddr   (reqAddr),
    .ctrl      (ctrl),
    .p0Beats   (p0Beats),
    .p1Beats   (p1Beats),
    .msgData   (msgData),
    .msgMark   (msgMark)
  );

  // R2
  start_after_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> (msgMark == MARK_START));

  // R2
  start_needs_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (msgMark == MARK_START) |-> $past(reqValid && reqReady));

  // R1
  ready_means_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (msgMark == MARK_EOM && msgData == '0));

  // R10
  idle_after_eom_chk: assert property (@(posedge clk) disable iff (!rstN)
    (msgMark == MARK_EOM && !reqReady) |=> (reqReady && msgData == '0));

  // R7
  addr_after_vend_chk: assert property (@(posedge clk) disable iff (!rstN)
    (msgMark == MARK_VEND) |=> (!reqReady && (msgMark == MARK_DATA || msgMark == MARK_EOM)));

endmodule

// File: tb/tb_trace_packetizer.sv
`timescale 1ns/1ps
module tb_trace_packetizer;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [1:0]  reqKind = '0;
  logic [3:0]  reqSrc = '0;
  logic [7:0]  reqStatus = '0;
  logic [31:0] reqProcId = '0;
  logic [7:0]  reqICnt = '0;
  logic [31:0] reqAddr = '0;
  logic [11:0] msgData;
  logic [1:0]  msgMark;

  always #10 clk = ~clk;

  trace_packetizer dut (
    .clk (clk), .rstN (rstN), .reqValid (reqValid), .reqReady (reqReady),
    .reqKind (reqKind), .reqSrc (reqSrc), .reqStatus (reqStatus),
    .reqProcId (reqProcId), .reqICnt (reqICnt), .reqAddr (reqAddr),
    .msgData (msgData), .msgMark (msgMark)
  );

  typedef struct {
    logic [1:0]  mark;
    logic [11:0] data;
    bit          idle;
    string       req;
  } beat_t;

  beat_t q[$];
  beat_t cur;
  int    checks = 0;
  int    errors = 0;
  bit    modelOn = 0;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic beat_t mk(logic [1:0] m, logic [11:0] d, bit idl, string r);
    beat_t b;
    b.mark = m; b.data = d; b.idle = idl; b.req = r;
    return b;
  endfunction

  function automatic int sigBits(logic [31:0] v);
    int n = 1;
    for (int i = 0; i < 32; i++) if (v[i]) n = i + 1;
    return n;
  endfunction

  // expected beats of the message captured with the current inputs
  function automatic void pushMsg();
    logic [5:0] code;
    int nb;
    case (reqKind)
      2'd0: code = 6'd0;
      2'd1: code = 6'd2;
      2'd2: code = 6'd3;
      default: code = 6'd4;
    endcase
    q.push_back(mk(2'b00, {2'b00, reqSrc, code}, 0, "R2/R3"));
    case (reqKind)
      2'd0: q.push_back(mk(2'b11, {4'h0, reqStatus}, 0, "R4"));
      2'd1: for (int k = 0; k < 3; k++)
              q.push_back(mk((k == 2) ? 2'b11 : 2'b10, 12'((reqProcId >> (12 * k)) & 32'hFFF), 0, "R5"));
      2'd2: q.push_back(mk(2'b11, {4'h0, reqICnt}, 0, "R6"));
      default: begin
        q.push_back(mk(2'b01, {4'h0, reqICnt}, 0, "R7"));
        nb = (sigBits(reqAddr) + 11) / 12;
        for (int k = 0; k < nb; k++)
          q.push_back(mk((k == nb - 1) ? 2'b11 : 2'b10, 12'((reqAddr >> (12 * k)) & 32'hFFF), 0, "R8"));
      end
    endcase
  endfunction

  // reference model, compared every cycle away from the active edge
  always @(negedge clk) begin
    if (modelOn) begin
      chk(cur.req, "msgMark", 32'(msgMark), 32'(cur.mark));
      chk(cur.req, "msgData", 32'(msgData), 32'(cur.data));
      chk("R9", "reqReady", 32'(reqReady), 32'(cur.idle));
      if (reqValid && cur.idle) pushMsg();
      if (q.size() > 0) cur = q.pop_front();
      else cur = mk(2'b11, 12'h000, 1, "R1/R10");
    end
  end

  task automatic send(logic [1:0] k, logic [3:0] s, logic [7:0] st, logic [31:0] pid,
                      logic [7:0] ic, logic [31:0] ad, bit hold);
    reqKind = k; reqSrc = s; reqStatus = st; reqProcId = pid; reqICnt = ic; reqAddr = ad;
    reqValid = 1'b1;
    do @(negedge clk); while (!reqReady);
    @(posedge clk);
    #2;
    if (!hold) reqValid = 1'b0;
  endtask

  // R9: fields change while busy; only handshake-time values may matter
  task automatic churn(int n);
    repeat (n) begin
      @(posedge clk);
      #2;
      reqKind = 2'($urandom); reqSrc = 4'($urandom); reqStatus = 8'($urandom);
      reqProcId = $urandom; reqICnt = 8'($urandom); reqAddr = $urandom;
    end
  endtask

  task automatic idle(int n);
    reqValid = 1'b0;
    repeat (n) @(posedge clk);
    #2;
  endtask

  initial begin
    cur = mk(2'b11, 12'h000, 1, "R1/R10");
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "msgMark in reset", 32'(msgMark), 32'h3);
    chk("R1", "msgData in reset", 32'(msgData), 32'h0);
    chk("R1", "reqReady in reset", 32'(reqReady), 32'h1);
    @(posedge clk);
    #2;
    rstN = 1'b1;
    modelOn = 1;
    idle(3);

    // R3 R4: debug status
    send(2'd0, 4'hA, 8'hC5, 32'h0, 8'h0, 32'h0, 0);
    idle(2);
    // R5: ownership
    send(2'd1, 4'h3, 8'h0, 32'hDEADBEEF, 8'h0, 32'h0, 0);
    idle(6);
    // R6: direct branch, one-bit minimum and full width
    send(2'd2, 4'h5, 8'h0, 32'h0, 8'h00, 32'h0, 0);
    idle(4);
    send(2'd2, 4'hF, 8'h0, 32'h0, 8'hFF, 32'h0, 0);
    idle(4);
    // R7 R8: indirect branch across beat boundaries
    send(2'd3, 4'h1, 8'h0, 32'h0, 8'h07, 32'h0000_0000, 0);
    idle(5);
    send(2'd3, 4'h2, 8'h0, 32'h0, 8'h80, 32'h0000_0FFF, 0);
    idle(5);
    send(2'd3, 4'h4, 8'h0, 32'h0, 8'h01, 32'h0000_1000, 0);
    idle(6);
    send(2'd3, 4'h6, 8'h0, 32'h0, 8'h3C, 32'h00FF_FFFF, 0);
    idle(6);
    send(2'd3, 4'h8, 8'h0, 32'h0, 8'h11, 32'h0100_0000, 0);
    idle(7);
    send(2'd3, 4'h9, 8'h0, 32'h0, 8'hFE, 32'hFFFF_FFFF, 0);
    idle(7);
    // R9 R10: back-to-back with valid held and fields churned while busy
    send(2'd1, 4'h7, 8'h0, 32'h1234_5678, 8'h0, 32'h0, 1);
    churn(2);
    send(2'd3, 4'hB, 8'h0, 32'h0, 8'h2A, 32'h0ABC_DEF1, 1);
    churn(2);
    send(2'd0, 4'hC, 8'h5A, 32'h0, 8'h0, 32'h0, 1);
    send(2'd2, 4'hD, 8'h0, 32'h0, 8'h09, 32'h0, 0);
    idle(12);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule